// File: doc/BRIEF.md
# Lockable Configuration Register Bank

This block is a small bank of byte-wide configuration registers for a peripheral controller. A host first loads an index register and then reads or writes the selected register through a data port. Every access, including a load of the index, is honoured only while the configuration-state input is high. Two registers are implemented. The first holds the floppy-controller power enable and a software validity flag. The second holds the parallel-port power enable, the parallel-port mode select and a lock-enable bit.

The lock-enable bit can be cleared by software but never set again by software. While it is clear, every read or write that targets index 0x00 through 0x2F is refused until a hard reset. A refused read returns 0x00, and a refused write changes nothing. Reserved bits return fixed patterns, some of which are non-zero. The power and mode bits drive control outputs directly. Clearing a power bit only turns the matching output off; address decoding elsewhere in the chip is not affected.

Reads are registered. The data port output takes the read value on the clock edge that samples the read strobe and holds it until the next read strobe.

Top module: `cfg_lock_bank`

## Requirements
- R1: After reset, register 0x00 reads 0x28 and register 0x01 reads 0x9C, and fdc_pwr_en, pp_pwr_en and pp_printer_mode are all 1.
- R2: While cfg_mode is 0, index loads and data writes are ignored, and a data read returns 0x00.
- R3: A data access targets the register whose number was last loaded into the index through idx_wr.
- R4: In register 0x00, bits 2:0 always read 0 and bits 6:4 always read 0b010 (bit 5 set), whatever value is written.
- R5: Bit 3 of register 0x00 is writable and drives fdc_pwr_en on the cycle after the write. Bit 7 of register 0x00 is a writable flag that is cleared at reset and affects no output.
- R6: In register 0x01, bits 1:0 always read 0, bit 4 always reads 1, and bits 6:5 always read 0.
- R7: Bit 2 of register 0x01 drives pp_pwr_en, and bit 3 of register 0x01 drives pp_printer_mode (1 selects printer mode, 0 selects the extended modes).
- R8: Writing 0 to bit 7 of register 0x01 clears the lock-enable bit. A later write of 1 does not set it again.
- R9: While the lock-enable bit is 0, reads of indices 0x00 to 0x2F return 0x00, and writes to those indices change no register or output.
- R10: A reset restores the lock-enable bit to 1 and restores full access.
- R11: Indices 0x02 and above read 0x00, and writes to them have no effect.
- R12: rdata is loaded on the clock edge that samples data_rd and holds its value while data_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| cfg_mode | input | 1 | High while the chip is in configuration state |
| idx_wr | input | 1 | Load strobe for the index register |
| data_wr | input | 1 | Write strobe for the data port |
| data_rd | input | 1 | Read strobe for the data port |
| wdata | input | 8 | Value for an index load or a data write |
| rdata | output | 8 | Registered read value of the data port |
| fdc_pwr_en | output | 1 | Floppy-controller power enable |
| pp_pwr_en | output | 1 | Parallel-port power enable |
| pp_printer_mode | output | 1 | 1 selects printer mode, 0 selects the extended modes |

## Verification
The assertions check on every cycle that the lock bit never returns to 1 once it is 0, that refused reads return zero, that the fixed bit patterns appear on every granted read, that the outputs stay still outside configuration state, and that rdata holds between read strobes. Only the bench's scenarios can show that specific values reach the registers through index and data writes. The same applies to the full clear-then-try-to-set sequence with its blocked accesses, and to the way a reset restores access after a lock.

// File: rtl/cfg_lock_bank_pkg.sv
// Package: shared constants for the lockable configuration bank.
// Per-register reset value, writable mask, fixed read value and
// clear-only mask, all indexed by register number.
package cfg_lock_bank_pkg;
    localparam int NREG = 2;
    localparam int DW   = 8;
    typedef logic [DW-1:0] byte_t;

    localparam byte_t RST_VAL   [NREG] = '{8'h28, 8'h9C};
    localparam byte_t RW_MASK   [NREG] = '{8'h88, 8'h8C};
    localparam byte_t RO_VAL    [NREG] = '{8'h20, 8'h10};
    localparam byte_t CLR_ONLY  [NREG] = '{8'h00, 8'h80};

    localparam int FDC_BIT  = 3;
    localparam int PPW_BIT  = 2;
    localparam int PRN_BIT  = 3;
    localparam int LOCK_BIT = 7;
endpackage

// File: rtl/cfg_index_reg.sv
// Module: index register.
// Captures wdata into the index on idx_wr while cfg_mode is high.
// Assumes the lock does not apply to the index itself.
module cfg_index_reg #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mode,
    input  logic             idx_wr,
    input  logic [IDX_W-1:0] wdata,
    output logic [IDX_W-1:0] idx_q
);
    // Load the index when the host strobes it in configuration state.
    always_ff @(posedge clk) begin
        if (!rst_n)                   idx_q <= '0;
        else if (cfg_mode && idx_wr)  idx_q <= wdata;
    end
endmodule

// File: rtl/cfg_access_gate.sv
// Module: access gate.
// Decodes the index into per-register selects and refuses any access
// that happens outside configuration state, or that targets the
// lockable range while the lock bit is clear.
// Assumes register numbers start at zero.
module cfg_access_gate #(
    parameter int IDX_W    = 8,
    parameter int NREG     = 2,
    parameter int LAST_IDX = 8'h2F
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             cfg_mode,
    input  logic             lock_en,
    input  logic             data_wr,
    input  logic             data_rd,
    output logic [NREG-1:0]  wr_sel,
    output logic [NREG-1:0]  rd_sel,
    output logic             rd_ok
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(LAST_IDX);

    logic in_range;
    logic allow;

    // Decide whether the current index may be touched at all.
    always_comb begin
        in_range = (idx <= LAST);
        allow    = cfg_mode && (lock_en || !in_range);
        rd_ok    = allow && data_rd;
    end

    for (genvar i = 0; i < NREG; i++) begin : g_sel
        // Select register i for a permitted access.
        always_comb begin
            wr_sel[i] = allow && data_wr && (idx == IDX_W'(i));
            rd_sel[i] = rd_ok && (idx == IDX_W'(i));
        end
    end
endmodule

// File: rtl/cfg_reg_store.sv
// Module: register storage.
// Holds one byte image per implemented register. A write merges the
// writable bits with the fixed pattern, and clear-only bits can only
// fall. Assumes register 1 carries the lock bit.
module cfg_reg_store
    import cfg_lock_bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREG-1:0] wr_sel,
    input  byte_t           wdata,
    output byte_t           img [NREG],
    output logic            lock_en
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        byte_t nxt;
        // Merge the write with the fixed bits and hold the clear-only bits down.
        always_comb begin
            nxt = ((wdata & RW_MASK[i]) | RO_VAL[i]) & ~(CLR_ONLY[i] & ~img[i]);
        end
        // Update the register image on a selected write.
        always_ff @(posedge clk) begin
            if (!rst_n)         img[i] <= RST_VAL[i];
            else if (wr_sel[i]) img[i] <= nxt;
        end
    end

    assign lock_en = img[1][LOCK_BIT];

    // R8: once clear, the lock bit stays clear until reset
    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_en |=> !lock_en);
endmodule

// File: rtl/cfg_lock_bank.sv
// Module: lockable configuration register bank (top).
// Puts together the index, the access gate and the storage, registers
// the read data and drives the power and mode outputs.
// Assumes single-cycle strobes. If idx_wr and a data strobe coincide,
// the data access uses the old index.
module cfg_lock_bank
    import cfg_lock_bank_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int LAST_IDX = 8'h2F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_mode,
    input  logic         idx_wr,
    input  logic         data_wr,
    input  logic         data_rd,
    input  logic [7:0]   wdata,
    output logic [7:0]   rdata,
    output logic         fdc_pwr_en,
    output logic         pp_pwr_en,
    output logic         pp_printer_mode
);
    logic [IDX_W-1:0] idx_q;
    logic [NREG-1:0]  wr_sel, rd_sel;
    logic             rd_ok, lock_en;
    byte_t            img [NREG];
    byte_t            rd_mux;

    cfg_index_reg #(.IDX_W(IDX_W)) idx_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .idx_wr(idx_wr),
        .wdata(IDX_W'(wdata)), .idx_q(idx_q));

    cfg_access_gate #(.IDX_W(IDX_W), .NREG(NREG), .LAST_IDX(LAST_IDX)) gate_i (
        .idx(idx_q), .cfg_mode(cfg_mode), .lock_en(lock_en),
        .data_wr(data_wr), .data_rd(data_rd),
        .wr_sel(wr_sel), .rd_sel(rd_sel), .rd_ok(rd_ok));

    cfg_reg_store store_i (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wdata(wdata),
        .img(img), .lock_en(lock_en));

    // Pick the selected register image, or zero when nothing is selected.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NREG; i++)
            if (rd_sel[i]) rd_mux = rd_mux | img[i];
    end

    // Capture the read value when a read strobe is sampled.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata <= '0;
        else if (data_rd) rdata <= rd_ok ? rd_mux : '0;
    end

    assign fdc_pwr_en      = img[0][FDC_BIT];
    assign pp_pwr_en       = img[1][PPW_BIT];
    assign pp_printer_mode = img[1][PRN_BIT];

    // R2 / R9: a refused read returns zero
    a_r9_blocked_read: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !(cfg_mode && lock_en) && idx_q <= IDX_W'(LAST_IDX)) |=> rdata == 8'h00);
    // R4: fixed bits of register 0x00 on a granted read
    a_r4_reg0_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && cfg_mode && lock_en && idx_q == '0) |=> (rdata & 8'h77) == 8'h20);
    // R6: fixed bits of register 0x01 on a granted read
    a_r6_reg1_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && cfg_mode && lock_en && idx_q == IDX_W'(1)) |=> (rdata & 8'h73) == 8'h10);
    // R2: outputs cannot move outside configuration state
    a_r2_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |=> $stable({fdc_pwr_en, pp_pwr_en, pp_printer_mode}));
    // R5: a granted write to register 0x00 reaches fdc_pwr_en
    a_r5_fdc_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && cfg_mode && lock_en && idx_q == '0) |=> fdc_pwr_en == $past(wdata[3]));
    // R12: read data holds between read strobes
    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !data_rd |=> $stable(rdata));
endmodule

// File: tb/cfg_lock_bank_tb_top.sv
module cfg_lock_bank_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0, cfg_mode = 1'b0, idx_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic fdc_pwr_en, pp_pwr_en, pp_printer_mode;
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    cfg_lock_bank dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .idx_wr(idx_wr),
        .data_wr(data_wr), .data_rd(data_rd), .wdata(wdata), .rdata(rdata),
        .fdc_pwr_en(fdc_pwr_en), .pp_pwr_en(pp_pwr_en), .pp_printer_mode(pp_printer_mode));

    // {index, write value, expected read-back}
    localparam int NV = 12;
    localparam logic [23:0] VEC [NV] = '{
        {8'h00, 8'hFF, 8'hA8}, {8'h00, 8'h00, 8'h20}, {8'h00, 8'h57, 8'h20},
        {8'h00, 8'h08, 8'h28}, {8'h01, 8'h8C, 8'h9C}, {8'h01, 8'hF3, 8'h90},
        {8'h01, 8'h84, 8'h94}, {8'h01, 8'h88, 8'h98}, {8'h05, 8'hFF, 8'h00},
        {8'h2F, 8'h55, 8'h00}, {8'h30, 8'hAA, 8'h00}, {8'h01, 8'h8C, 8'h9C}};

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic pulse_idx(input logic [7:0] v);
        @(negedge clk); idx_wr = 1'b1; wdata = v;
        @(negedge clk); idx_wr = 1'b0;
    endtask

    task automatic pulse_wr(input logic [7:0] v);
        @(negedge clk); data_wr = 1'b1; wdata = v;
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic pulse_rd(output logic [7:0] v);
        @(negedge clk); data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0; v = rdata;
    endtask

    task automatic do_reset;
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] r, hold;
        do_reset();
        cfg_mode = 1'b1;
        // R1 reset state
        pulse_idx(8'h00); pulse_rd(r); check("R1 reg0", r, 8'h28);
        pulse_idx(8'h01); pulse_rd(r); check("R1 reg1", r, 8'h9C);
        check("R1 outputs", {5'd0, fdc_pwr_en, pp_pwr_en, pp_printer_mode}, 8'h07);

        // R3 R4 R6 R11 vector walk
        for (int k = 0; k < NV; k++) begin
            pulse_idx(VEC[k][23:16]);
            pulse_wr(VEC[k][15:8]);
            pulse_rd(r);
            check("R3/R4/R6/R11 vector", r, VEC[k][7:0]);
        end

        // R7 mode and power outputs
        pulse_idx(8'h01); pulse_wr(8'h80);
        check("R7 pp bits low", {6'd0, pp_pwr_en, pp_printer_mode}, 8'h00);
        pulse_wr(8'h8C);
        check("R7 pp bits high", {6'd0, pp_pwr_en, pp_printer_mode}, 8'h03);

        // R5 fdc power and validity flag
        pulse_idx(8'h00); pulse_wr(8'h00);
        check("R5 fdc off", {7'd0, fdc_pwr_en}, 8'h00);
        pulse_wr(8'h80);
        check("R5 flag no output effect", {5'd0, fdc_pwr_en, pp_pwr_en, pp_printer_mode}, 8'h03);
        pulse_rd(r); check("R5 flag read", r, 8'hA0);

        // R12 hold between strobes
        hold = rdata;
        repeat (3) @(negedge clk);
        check("R12 hold", rdata, hold);

        // R2 outside configuration state
        cfg_mode = 1'b0;
        pulse_idx(8'h01); pulse_wr(8'h08);
        check("R2 write ignored", {7'd0, fdc_pwr_en}, 8'h00);
        pulse_rd(r); check("R2 read zero", r, 8'h00);
        cfg_mode = 1'b1;
        pulse_rd(r); check("R2 index kept", r, 8'hA0);

        // R8 R9 lock clear and attempted re-set
        pulse_idx(8'h01); pulse_wr(8'h0C);
        pulse_rd(r); check("R9 locked read reg1", r, 8'h00);
        pulse_wr(8'h80);
        pulse_wr(8'h80);
        pulse_rd(r); check("R8 lock not re-set", r, 8'h00);
        pulse_wr(8'h80);
        check("R9 outputs kept", {6'd0, pp_pwr_en, pp_printer_mode}, 8'h03);
        pulse_idx(8'h00); pulse_wr(8'h08);
        check("R9 fdc write blocked", {7'd0, fdc_pwr_en}, 8'h00);
        pulse_rd(r); check("R9 locked read reg0", r, 8'h00);

        // R10 reset restores access
        do_reset();
        pulse_idx(8'h01); pulse_rd(r); check("R10 reg1 after reset", r, 8'h9C);
        pulse_idx(8'h00); pulse_wr(8'h00);
        check("R10 write works", {7'd0, fdc_pwr_en}, 8'h00);
        pulse_rd(r); check("R10 reg0 read", r, 8'h20);

        finish_run();
    end
endmodule